// File: doc/BRIEF.md
# Word-Serial Stream Cipher Message Engine

This block runs one confidentiality job at a time. It takes a job as a sequence of 32-bit words on an input stream: a seven-word header first, then the payload. From the header it collects a 128-bit key, a 32-bit counter, a 5-bit channel identifier, a one-bit link direction flag and a message length in bits. It then seeds an external keystream generator with that key and an initialisation vector built from the counter, channel and direction.

After seeding, the engine consumes payload words one at a time. Each payload word is combined by bitwise XOR with one keystream word, which the engine takes from the generator in step with the payload word. The result leaves on a 32-bit output stream with valid/ready handshaking. In the final word, the bits past the message length are forced to zero. A pulse on `done` marks the end of the job. A job of zero length produces no output and finishes right after its header. When the output is stalled, the engine holds the input stream and the keystream port without losing a word.

Top module: `msg_cipher_engine`

## Requirements
- R1: After reset, `out_valid`, `done` and `gen_init` are low and `in_ready` is high, waiting for header word 0.
- R2: Header words 0, 1, 2 and 3 are key bits 31:0, 63:32, 95:64 and 127:96. `gen_key` carries that key while `gen_init` is high.
- R3: Header word 4 is the counter and header word 5 carries the channel in bits 5:1 and the direction in bit 0. `gen_iv` is {counter, channel, direction, 26 zero bits} repeated twice, with the first copy in bits 127:64.
- R4: For a nonzero length (header word 6), `gen_init` is high for exactly one cycle: the cycle after header word 6 is accepted. `in_ready` is low in that cycle.
- R5: Output word i equals payload word i XOR the i-th keystream word handed over after seeding, in order. Exactly one keystream word is taken (`ks_take` and `ks_valid` both high) per payload word.
- R6: A job with length L produces exactly ceil(L/32) output words.
- R7: Message bit k sits at bit k mod 32 of payload word k/32. In the last output word, bits at positions L mod 32 and above read zero whatever the input padding holds, unless L is a multiple of 32, in which case the whole word is kept.
- R8: A length of zero gives no `gen_init`, no keystream take and no output word. `done` is high in the cycle after header word 6 is accepted.
- R9: For a nonzero length, `done` is a one-cycle pulse in the cycle after the last output word is accepted.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` holds its value, and `in_ready` and `ks_take` stay low.
- R11: A payload word is consumed only when the input word and a keystream word are both present. Gaps on either side lose no data and duplicate none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Engine accepts the input word this cycle |
| in_data | input | 32 | Header or payload word |
| gen_init | output | 1 | One-cycle seed strobe to the keystream generator |
| gen_key | output | 128 | Key for the generator |
| gen_iv | output | 128 | Initialisation vector for the generator |
| ks_valid | input | 1 | Generator has a keystream word ready |
| ks_take | output | 1 | Engine takes the keystream word when `ks_valid` is high |
| ks_data | input | 32 | Keystream word |
| out_valid | output | 1 | Ciphered word present |
| out_ready | input | 1 | Downstream accepts the ciphered word |
| out_data | output | 32 | Ciphered word |
| done | output | 1 | End-of-job pulse |

## Verification
Every result follows a fixed delay. `gen_init` is due one cycle after the handshake on header word 6. A ciphered word appears on `out_data` one cycle after its input and keystream handshake. `done` follows one cycle after the handshake of the final output word, or one cycle after header word 6 when the length is zero. The bench drives inputs on the falling edge and samples all outputs a short delay after it. It stamps each handshake with the count of rising edges so far, and each delay is checked as an exact difference of those stamps. Stall and hold behaviour is checked on every sampled cycle, and the counts of output words and keystream takes are compared at the end of each job.

// File: rtl/msg_cipher_pkg.sv
package msg_cipher_pkg;

   // Control phases of one job.
   typedef enum logic [1:0] {
      ST_HDR   = 2'd0,
      ST_SEED  = 2'd1,
      ST_BODY  = 2'd2,
      ST_FLUSH = 2'd3
   } seq_state_t;

   // Width of the header slot index; the header is key words plus three.
   localparam int unsigned HDR_IDX_W = 3;

endpackage

// File: rtl/msg_hdr_capture.sv
module msg_hdr_capture #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned KEY_W    = 128,
   parameter int unsigned BEARER_W = 5,
   parameter int unsigned IDX_W    = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      capture,
   input  logic [IDX_W-1:0]          idx,
   input  logic [WORD_W-1:0]         word,
   output logic [KEY_W-1:0]          key,
   output logic [4*WORD_W-1:0]       iv,
   output logic [$clog2(WORD_W)-1:0] tail
);
   localparam int unsigned KEY_WORDS  = KEY_W / WORD_W;
   localparam int unsigned SLOT_COUNT = KEY_WORDS;
   localparam int unsigned SLOT_MODE  = KEY_WORDS + 1;
   localparam int unsigned SLOT_LEN   = KEY_WORDS + 2;
   localparam int unsigned PAD_W      = WORD_W - BEARER_W - 1;
   localparam int unsigned TAIL_W     = $clog2(WORD_W);

   if (KEY_W % WORD_W != 0) begin : g_bad_key
      $error("key width must be a whole number of words");
   end
   if (SLOT_LEN >= (1 << IDX_W)) begin : g_bad_idx
      $error("header index too narrow for the header length");
   end
   if (WORD_W < BEARER_W + 2) begin : g_bad_mode
      $error("word too narrow for channel and direction fields");
   end

   logic [WORD_W-1:0]   count_q;
   logic [BEARER_W-1:0] bearer_q;
   logic                dir_q;
   logic [TAIL_W-1:0]   tail_q;

   // One register per key word, selected by header slot.
   for (genvar gk = 0; gk < KEY_WORDS; gk++) begin : g_key
      logic [WORD_W-1:0] part_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            part_q <= '0;
         end else if (capture && idx == IDX_W'(gk)) begin
            part_q <= word;
         end
      end
      assign key[gk*WORD_W +: WORD_W] = part_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         bearer_q <= '0;
         dir_q    <= 1'b0;
         tail_q   <= '0;
      end else if (capture) begin
         if (idx == IDX_W'(SLOT_COUNT)) count_q <= word;
         if (idx == IDX_W'(SLOT_MODE)) begin
            bearer_q <= word[BEARER_W:1];
            dir_q    <= word[0];
         end
         if (idx == IDX_W'(SLOT_LEN)) tail_q <= word[TAIL_W-1:0];
      end
   end

   assign iv   = {2{count_q, bearer_q, dir_q, {PAD_W{1'b0}}}};
   assign tail = tail_q;

endmodule

// File: rtl/msg_seq_ctrl.sv
module msg_seq_ctrl
   import msg_cipher_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned LEN_W     = 32,
   parameter int unsigned IDX_W     = 3,
   parameter int unsigned LAST_SLOT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [LEN_W-1:0] in_len,
   input  logic             ks_valid,
   input  logic             slot_free,
   input  logic             out_fire,
   output logic             in_ready,
   output logic             ks_take,
   output logic             hdr_capture,
   output logic [IDX_W-1:0] hdr_idx,
   output logic             gen_init,
   output logic             body_load,
   output logic             body_last,
   output logic             done
);
   localparam int unsigned SHIFT = $clog2(WORD_W);
   localparam int unsigned CNT_W = LEN_W - SHIFT + 1;

   if (LEN_W <= SHIFT) begin : g_bad_len
      $error("length field narrower than a word index");
   end

   seq_state_t        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CNT_W-1:0]  left_q;
   logic [CNT_W-1:0]  words;
   logic              done_q;
   logic              in_hdr, in_body;

   assign words   = CNT_W'(({1'b0, in_len} + (LEN_W+1)'(WORD_W - 1)) >> SHIFT);
   assign in_hdr  = (state_q == ST_HDR);
   assign in_body = (state_q == ST_BODY);

   always_comb begin
      in_ready    = in_hdr | (in_body & ks_valid & slot_free);
      ks_take     = in_body & in_valid & slot_free;
      hdr_capture = in_hdr & in_valid;
      body_load   = in_body & in_valid & ks_valid & slot_free;
      body_last   = body_load & (left_q == CNT_W'(1));
      gen_init    = (state_q == ST_SEED);
      done        = done_q;
      hdr_idx     = idx_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HDR;
         idx_q   <= '0;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_HDR: begin
               if (in_valid) begin
                  if (idx_q == IDX_W'(LAST_SLOT)) begin
                     idx_q <= '0;
                     if (in_len == '0) begin
                        done_q <= 1'b1;
                     end else begin
                        left_q  <= words;
                        state_q <= ST_SEED;
                     end
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_SEED: state_q <= ST_BODY;
            ST_BODY: begin
               if (body_load) begin
                  left_q <= left_q - 1'b1;
                  if (left_q == CNT_W'(1)) state_q <= ST_FLUSH;
               end
            end
            ST_FLUSH: begin
               if (out_fire) begin
                  done_q  <= 1'b1;
                  state_q <= ST_HDR;
               end
            end
            default: state_q <= ST_HDR;
         endcase
      end
   end

   // R4
   seed_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_init |=> !gen_init);

   // R4
   seed_no_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_init |-> !in_ready);

   // R10
   stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_free |-> (!in_ready && !ks_take));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/msg_out_stage.sv
module msg_out_stage #(
   parameter int unsigned WORD_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic                      last,
   input  logic [$clog2(WORD_W)-1:0] tail,
   input  logic [WORD_W-1:0]         pt,
   input  logic [WORD_W-1:0]         ks,
   input  logic                      out_ready,
   output logic                      out_valid,
   output logic [WORD_W-1:0]         out_data,
   output logic                      slot_free
);
   localparam int unsigned TAIL_W = $clog2(WORD_W);

   logic [WORD_W-1:0] keep;
   logic [WORD_W-1:0] data_q;
   logic              valid_q;

   // Per-bit keep mask: a bit survives unless it lies past the message end.
   for (genvar gb = 0; gb < WORD_W; gb++) begin : g_keep
      assign keep[gb] = !last || (tail == '0) || (TAIL_W'(gb) < tail);
   end

   assign slot_free = !valid_q || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
      end else if (load) begin
         data_q  <= (pt ^ ks) & keep;
         valid_q <= 1'b1;
      end else if (out_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign out_valid = valid_q;
   assign out_data  = data_q;

   // R10
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/msg_cipher_engine.sv
module msg_cipher_engine
   import msg_cipher_pkg::*;
#(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned KEY_W    = 128,
   parameter int unsigned BEARER_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [WORD_W-1:0]   in_data,
   output logic                gen_init,
   output logic [KEY_W-1:0]    gen_key,
   output logic [4*WORD_W-1:0] gen_iv,
   input  logic                ks_valid,
   output logic                ks_take,
   input  logic [WORD_W-1:0]   ks_data,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [WORD_W-1:0]   out_data,
   output logic                done
);
   localparam int unsigned KEY_WORDS = KEY_W / WORD_W;
   localparam int unsigned LAST_SLOT = KEY_WORDS + 2;
   localparam int unsigned TAIL_W    = $clog2(WORD_W);

   if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("word width must be a power of two of at least 8");
   end

   logic                 hdr_capture;
   logic [HDR_IDX_W-1:0] hdr_idx;
   logic [TAIL_W-1:0]    tail;
   logic                 slot_free;
   logic                 body_load, body_last;
   logic                 out_fire;

   assign out_fire = out_valid && out_ready;

   msg_hdr_capture #(
      .WORD_W   (WORD_W),
      .KEY_W    (KEY_W),
      .BEARER_W (BEARER_W),
      .IDX_W    (HDR_IDX_W)
   ) u_hdr (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (hdr_capture),
      .idx     (hdr_idx),
      .word    (in_data),
      .key     (gen_key),
      .iv      (gen_iv),
      .tail    (tail)
   );

   msg_seq_ctrl #(
      .WORD_W    (WORD_W),
      .LEN_W     (WORD_W),
      .IDX_W     (HDR_IDX_W),
      .LAST_SLOT (LAST_SLOT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_len      (in_data),
      .ks_valid    (ks_valid),
      .slot_free   (slot_free),
      .out_fire    (out_fire),
      .in_ready    (in_ready),
      .ks_take     (ks_take),
      .hdr_capture (hdr_capture),
      .hdr_idx     (hdr_idx),
      .gen_init    (gen_init),
      .body_load   (body_load),
      .body_last   (body_last),
      .done        (done)
   );

   msg_out_stage #(
      .WORD_W (WORD_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (body_load),
      .last      (body_last),
      .tail      (tail),
      .pt        (in_data),
      .ks        (ks_data),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .slot_free (slot_free)
   );

   // R11
   ks_with_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ks_take && ks_valid) |-> (in_valid && in_ready));

endmodule

// File: tb/msg_cipher_engine_test.sv
module msg_cipher_engine_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [31:0]  in_data = '0;
   logic         gen_init;
   logic [127:0] gen_key;
   logic [127:0] gen_iv;
   logic         ks_valid;
   logic         ks_take;
   logic [31:0]  ks_data;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [31:0]  out_data;
   logic         done;

   always #10 clk = ~clk;   // 50 MHz

   msg_cipher_engine uut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
      .gen_init (gen_init), .gen_key (gen_key), .gen_iv (gen_iv),
      .ks_valid (ks_valid), .ks_take (ks_take), .ks_data (ks_data),
      .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
      .done (done)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit ended  = 0;

   int in_gap = 0, out_mod = 0, ks_mod = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] mix(input logic [31:0] a, input logic [31:0] b);
      return (a * 32'h9E3779B1) ^ (b + 32'h7F4A7C15) ^ {a[15:0], a[31:16]};
   endfunction

   function automatic logic [31:0] ks_fn(input logic [127:0] k, input logic [127:0] v,
                                         input logic [31:0] i);
      return mix(k[31:0] ^ k[95:64] ^ v[63:32] ^ i, k[63:32] ^ k[127:96] ^ v[31:0])
             ^ v[127:96] ^ v[95:64];
   endfunction

   // Keystream generator model.
   logic [127:0] m_key = '0, m_iv = '0;
   logic [31:0]  m_idx = '0;
   logic         m_armed = 1'b0;

   always @(posedge clk) begin
      if (gen_init) begin
         m_key <= gen_key; m_iv <= gen_iv; m_idx <= '0; m_armed <= 1'b1;
      end else if (ks_take && ks_valid) begin
         m_idx <= m_idx + 1;
      end
   end
   assign ks_valid = m_armed && (ks_mod == 0 || (cyc % ks_mod) != 0);
   assign ks_data  = ks_fn(m_key, m_iv, m_idx);

   // Monitor: sampled 2 ns after each falling edge.
   logic [31:0]  got [0:63];
   int           out_cnt = 0, ks_cnt = 0, init_cnt = 0, done_cnt = 0, stall_viol = 0;
   int           last_out_stamp = 0, init_stamp = 0, done_stamp = 0, hdr6_stamp = 0;
   logic [127:0] init_key = '0, init_iv = '0;
   bit           prev_stall = 0;
   logic [31:0]  prev_data = '0;

   initial begin
      forever begin
         @(negedge clk);
         out_ready = (out_mod == 0) || ((cyc % out_mod) != 0);
         #2;
         if (rst_n) begin
            if (prev_stall && (!out_valid || out_data != prev_data)) stall_viol++;
            if (out_valid && !out_ready && (in_ready || ks_take)) stall_viol++;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
               if (out_cnt < 64) got[out_cnt] = out_data;
               out_cnt++;
               last_out_stamp = cyc;
            end
            if (ks_take && ks_valid) ks_cnt++;
            if (gen_init) begin
               init_cnt++; init_stamp = cyc; init_key = gen_key; init_iv = gen_iv;
            end
            if (done) begin
               done_cnt++; done_stamp = cyc;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   task automatic send_word(input logic [31:0] w, output int stamp);
      repeat (in_gap) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      #2;
      while (!in_ready) begin
         @(negedge clk);
         #2;
      end
      stamp = cyc;
      @(posedge clk);
   endtask

   task automatic run_job(input string name, input logic [127:0] key, input logic [31:0] count,
                          input logic [4:0] bearer, input logic dir, input logic [31:0] len,
                          input int ig, input int og, input int kg);
      logic [31:0]  pay [0:15];
      logic [127:0] iv_exp;
      int           n_exp, st;
      logic [31:0]  exp, mask;
      in_gap = ig; out_mod = og; ks_mod = kg;
      out_cnt = 0; ks_cnt = 0; init_cnt = 0; done_cnt = 0; stall_viol = 0;
      n_exp  = int'((64'(len) + 31) / 32);
      iv_exp = {2{count, bearer, dir, 26'b0}};
      for (int i = 0; i < 16; i++) pay[i] = mix(32'(i) ^ count, key[31:0] + 32'(len));
      for (int i = 0; i < 4; i++) send_word(key[i*32 +: 32], st);
      send_word(count, st);
      send_word({26'h2A5_5A5A, bearer, dir} & {26'b0, 6'h3F}, st);
      send_word(len, hdr6_stamp);
      for (int i = 0; i < n_exp; i++) send_word(pay[i], st);
      @(negedge clk);
      in_valid = 1'b0;
      while (done_cnt == 0) @(negedge clk);
      repeat (3) @(negedge clk);
      // R6
      chk(out_cnt == n_exp, {name, " R6 word count"}, 128'(out_cnt), 128'(n_exp));
      for (int i = 0; i < n_exp && i < 16; i++) begin
         mask = 32'hFFFF_FFFF;
         if (i == n_exp - 1 && len[4:0] != 0) mask = (32'h1 << len[4:0]) - 1;
         exp = (pay[i] ^ ks_fn(key, iv_exp, 32'(i))) & mask;
         if (i == n_exp - 1)
            chk(got[i] == exp, {name, " R7 last word mask"}, 128'(got[i]), 128'(exp));
         else
            chk(got[i] == exp, {name, " R5 cipher word"}, 128'(got[i]), 128'(exp));
      end
      if (len != 0) begin
         // R2 R3 R4
         chk(init_cnt == 1, {name, " R4 seed count"}, 128'(init_cnt), 128'd1);
         chk(init_stamp == hdr6_stamp + 1, {name, " R4 seed timing"},
             128'(init_stamp), 128'(hdr6_stamp + 1));
         chk(init_key == key, {name, " R2 key"}, init_key, key);
         chk(init_iv == iv_exp, {name, " R3 iv"}, init_iv, iv_exp);
         // R5 R11 one keystream word per payload word
         chk(ks_cnt == n_exp, {name, " R11 keystream takes"}, 128'(ks_cnt), 128'(n_exp));
         // R9
         chk(done_stamp == last_out_stamp + 1, {name, " R9 done timing"},
             128'(done_stamp), 128'(last_out_stamp + 1));
      end else begin
         // R8
         chk(init_cnt == 0 && ks_cnt == 0, {name, " R8 no seed"},
             128'(init_cnt + ks_cnt), 128'd0);
         chk(done_stamp == hdr6_stamp + 1, {name, " R8 done timing"},
             128'(done_stamp), 128'(hdr6_stamp + 1));
      end
      chk(done_cnt == 1, {name, " R9 single done"}, 128'(done_cnt), 128'd1);
      // R10
      chk(stall_viol == 0, {name, " R10 stall hold"}, 128'(stall_viol), 128'd0);
      in_gap = 0; out_mod = 0; ks_mod = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      #2;
      // R1
      chk(!out_valid && !done && !gen_init, "R1 outputs idle", 
          {125'b0, out_valid, done, gen_init}, 128'd0);
      chk(in_ready, "R1 ready for header", 128'(in_ready), 128'd1);
   endtask

   task automatic t_full_words();
      run_job("full", 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0, 32'h6630_2415,
              5'h0C, 1'b1, 32'd96, 0, 0, 0);
   endtask

   task automatic t_partial();
      run_job("partial", 128'h11112222_33334444_55556666_77778888, 32'hDEAD_0001,
              5'h15, 1'b0, 32'd70, 0, 0, 0);
   endtask

   task automatic t_single_bit();
      run_job("onebit", 128'hA5A5A5A5_5A5A5A5A_0000FFFF_FFFF0000, 32'h0000_0007,
              5'h01, 1'b1, 32'd1, 0, 0, 0);
   endtask

   task automatic t_len_zero();
      run_job("empty", 128'h01234567_89ABCDEF_FEDCBA98_76543210, 32'h1234_5678,
              5'h1F, 1'b1, 32'd0, 0, 0, 0);
   endtask

   task automatic t_backpressure();
      run_job("stall", 128'hCAFEF00D_0BADBEEF_13579BDF_2468ACE0, 32'h8000_0000,
              5'h0A, 1'b0, 32'd200, 0, 3, 0);
   endtask

   task automatic t_starved();
      run_job("starve", 128'h31415926_53589793_23846264_33832795, 32'h0000_FFFF,
              5'h03, 1'b1, 32'd130, 2, 0, 3);
   endtask

   task automatic t_mixed();
      run_job("mixed", 128'hFFFFFFFF_00000000_FFFFFFFF_00000001, 32'hFFFF_FFFF,
              5'h1F, 1'b1, 32'd33, 1, 2, 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full_words();
      t_partial();
      t_single_bit();
      t_len_zero();
      t_backpressure();
      t_starved();
      t_mixed();
      finish_run();
   end

endmodule